// File: doc/BRIEF.md
# Four-Channel Edge-Timestamp Capture Unit

This unit records the value of a shared free-running count at the moment an external signal changes level. It watches four asynchronous capture pins. Each pin has its own choice of rising or falling edge. When the chosen edge arrives, the current count is stored in that channel's capture register, and the channel raises a sticky flag. Per-channel interrupt enables gate the flags into one combined interrupt request.

Two channels can be paired to keep a history. When pairing is on for the first pair, a new capture on channel A first pushes A's old value into C. The second pair does the same for B and D. This gives a two-deep record of the last two timestamps without software having to move data in time. While a pair is chained, the pins of the buffer channels (C or D) are ignored.

The count source, the bus that reads the registers and the interrupt controller all sit outside this block. The count arrives on an input port. Software reads one capture register at a time through a select and a registered data port.

Top module: `cap_quad`

## Requirements
- R1: While `rst` is high, and after it falls until the first capture, all four capture registers read 0x0000. `flags_o` is 0000 and `irq_o` is 0.
- R2: Each pin passes through a two-flop synchronizer before edge detection. Suppose a pin change is set up before clock edge k. Then the channel flag reads 1 after edge k+2 and still reads 0 after edge k+1. The stored value is the `count_i` presented in the cycle just before edge k+2.
- R3: `edge_rise_i[i]` = 1 selects the rising edge of `cap_pin_i[i]`, and 0 selects the falling edge. The opposite edge neither writes the register nor sets the flag.
- R4: Flags stay set until cleared. A cycle with `clr_we_i` = 1 clears every flag whose bit in `clr_mask_i` is 1. If a capture for the same channel occurs in that same cycle, the capture wins and the flag stays 1.
- R5: `irq_o` is registered. It is 1 one cycle after any flag i is set while `irq_en_i[i]` is 1, and it is 0 one cycle after no enabled flag remains.
- R6: With `buf_en_i[0]` = 1, a capture on pin A copies the old A value into C and loads the new count into A in the same cycle. Only flag A (bit 0) is set.
- R7: With `buf_en_i[1]` = 1, a capture on pin B copies the old B value into D and loads the new count into B in the same cycle. Only flag B (bit 1) is set.
- R8: While `buf_en_i[0]` (or `buf_en_i[1]`) is 1, edges on pin C (or pin D) leave register C (or D) unchanged and do not set flag C (bit 2) or flag D (bit 3).
- R9: `rd_sel_i` values 0, 1, 2 and 3 select registers A, B, C and D. `rd_data_o` shows the selected register one clock after the select is applied.
- R10: A capture on one channel leaves the registers of all other channels unchanged, except for the chained transfer of R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CW | Free-running count to timestamp |
| cap_pin_i | input | 4 | Asynchronous capture pins, bit 0 = A to bit 3 = D |
| edge_rise_i | input | 4 | Per-channel edge choice: 1 = rising, 0 = falling |
| buf_en_i | input | 2 | Chain enables: bit 0 pairs A with C, bit 1 pairs B with D |
| irq_en_i | input | 4 | Per-channel interrupt enables |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 4 | Flags to clear when the strobe is high |
| rd_sel_i | input | 2 | Capture register select, 0..3 = A..D |
| rd_data_o | output | CW | Registered read data |
| flags_o | output | 4 | Sticky capture flags |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
A pin change reaches the flags two clock edges after it is first sampled. It reaches `irq_o` three edges after, and a read select reaches `rd_data_o` one edge later. The bench drives every input just after a falling clock edge and samples just after the next one. It counts rising edges so that it looks at each result in exactly the cycle it becomes due. To show that the stored count belongs to the detection cycle, the count is changed every cycle around a capture. The count is also changed before each unselected return edge, so that a wrong-edge capture would leave a visibly different value.

// File: rtl/cap_quad_pkg.sv
package cap_quad_pkg;
  localparam int NCH   = 4;
  localparam int NPAIR = NCH / 2;

  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2,
    SEL_D = 2'd3
  } cap_sel_e;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] rise_sel_i,
  output logic [NCH-1:0] evt_o
);
  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      // sh[0], sh[1]: two-flop synchronizer; sh[2]: previous synchronized level
      logic [2:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], pin_i[i]};
      end
      assign evt_o[i] = rise_sel_i[i] ? (sh[1] & ~sh[2]) : (~sh[1] & sh[2]);

      // R3: a selected edge yields a single-cycle event
      assert_single_evt_R3: assert property (@(posedge clk) disable iff (rst)
        evt_o[i] |=> (!evt_o[i] || (rise_sel_i[i] != $past(rise_sel_i[i]))));
    end
  endgenerate
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          evt_i,
  input  logic [CW-1:0]       count_i,
  input  logic [1:0]          buf_en_i,
  input  logic                clr_we_i,
  input  logic [3:0]          clr_mask_i,
  output logic [3:0][CW-1:0]  creg_o,
  output logic [3:0]          flag_o
);
  import cap_quad_pkg::*;

  logic [3:0] set_w;
  logic [3:0] clr_w;

  genvar p;
  generate
    for (p = 0; p < NPAIR; p++) begin : g_pair
      logic [CW-1:0] lo_q;
      logic [CW-1:0] hi_q;
      logic          ld_lo;
      logic          shift_hi;
      logic          ld_hi;

      assign ld_lo    = evt_i[p];
      assign shift_hi = evt_i[p] & buf_en_i[p];
      assign ld_hi    = evt_i[p+NPAIR] & ~buf_en_i[p];

      always_ff @(posedge clk) begin
        if (rst) begin
          lo_q <= '0;
          hi_q <= '0;
        end else begin
          if (ld_lo) lo_q <= count_i;
          if (shift_hi)   hi_q <= lo_q;
          else if (ld_hi) hi_q <= count_i;
        end
      end

      assign creg_o[p]       = lo_q;
      assign creg_o[p+NPAIR] = hi_q;
      assign set_w[p]        = ld_lo;
      assign set_w[p+NPAIR]  = ld_hi;

      // R2: a detected edge stores the count of that cycle
      assert_load_lo_R2: assert property (@(posedge clk) disable iff (rst)
        evt_i[p] |=> (creg_o[p] == $past(count_i)));
      // R6 / R7: chained transfer of the previous low value
      assert_chain_shift_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_i[p] && buf_en_i[p]) |=> (creg_o[p+NPAIR] == $past(creg_o[p])));
      // R8: buffer register ignores its own pin while chained
      assert_chain_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (buf_en_i[p] && !evt_i[p]) |=> $stable(creg_o[p+NPAIR]));
    end
  endgenerate

  assign clr_w = clr_we_i ? clr_mask_i : 4'b0000;

  always_ff @(posedge clk) begin
    if (rst) flag_o <= '0;
    else     flag_o <= (flag_o & ~clr_w) | set_w;
  end

  // R4: a capture in the clear cycle keeps the flag
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_i[0] && clr_we_i && clr_mask_i[0]) |=> flag_o[0]);
endmodule

// File: rtl/cap_quad.sv
module cap_quad #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic [3:0]    cap_pin_i,
  input  logic [3:0]    edge_rise_i,
  input  logic [1:0]    buf_en_i,
  input  logic [3:0]    irq_en_i,
  input  logic          clr_we_i,
  input  logic [3:0]    clr_mask_i,
  input  logic [1:0]    rd_sel_i,
  output logic [CW-1:0] rd_data_o,
  output logic [3:0]    flags_o,
  output logic          irq_o
);
  import cap_quad_pkg::*;

  logic [NCH-1:0]         evt;
  logic [3:0][CW-1:0]     creg;
  cap_sel_e               sel;

  cap_edge_det #(.NCH(NCH)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (cap_pin_i),
    .rise_sel_i (edge_rise_i),
    .evt_o      (evt)
  );

  cap_store #(.CW(CW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .count_i    (count_i),
    .buf_en_i   (buf_en_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .creg_o     (creg),
    .flag_o     (flags_o)
  );

  assign sel = cap_sel_e'(rd_sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      rd_data_o <= creg[sel];
      irq_o     <= |(flags_o & irq_en_i);
    end
  end

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chk
      // R3 / R8: a flag only rises after its own pin produced an event
      assert_flag_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[i]) |-> $past(evt[i]));
    end
  endgenerate

  // R5: request only follows an enabled flag
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(flags_o & irq_en_i)));
  // R1: outputs are quiet in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && (flags_o == 4'b0000)));
endmodule

// File: tb/cap_quad_test.sv
`timescale 1ns/1ps
module cap_quad_test;
  localparam int CW = 16;
  localparam logic [3:0] RISE = 4'b0101; // A,C rising; B,D falling

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] count_i = '0;
  logic [3:0]    cap_pin_i = ~RISE;
  logic [3:0]    edge_rise_i = RISE;
  logic [1:0]    buf_en_i = 2'b00;
  logic [3:0]    irq_en_i = 4'b0000;
  logic          clr_we_i = 1'b0;
  logic [3:0]    clr_mask_i = 4'b0000;
  logic [1:0]    rd_sel_i = 2'd0;
  logic [CW-1:0] rd_data_o;
  logic [3:0]    flags_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] model [4] = '{default: '0};

  always #2.5 clk = ~clk;

  cap_quad #(.CW(CW)) uut (.*);

  // {buf_en[1:0], channel[1:0], count[15:0]}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {2'b00, 2'd0, 16'h1111}, {2'b00, 2'd1, 16'h2222},
    {2'b00, 2'd2, 16'h3333}, {2'b00, 2'd3, 16'h4444},
    {2'b01, 2'd0, 16'h5555}, {2'b01, 2'd2, 16'h6666},
    {2'b10, 2'd1, 16'h7777}, {2'b10, 2'd3, 16'h8888},
    {2'b11, 2'd0, 16'h9999}, {2'b11, 2'd1, 16'hABCD},
    {2'b00, 2'd2, 16'h0F0F}
  };

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [CW-1:0] v);
    @(negedge clk); rd_sel_i = s;
    @(negedge clk); v = rd_data_o;
  endtask

  task automatic pulse(input int ch, input logic [CW-1:0] cnt);
    @(negedge clk); count_i = cnt; cap_pin_i[ch] = RISE[ch];
    repeat (6) @(negedge clk);
    count_i = ~cnt; cap_pin_i[ch] = ~RISE[ch];
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_we_i = 1'b1; clr_mask_i = 4'b1111;
    @(negedge clk); clr_we_i = 1'b0; clr_mask_i = 4'b0000;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [CW-1:0] v;
    logic [3:0] expf;
    repeat (4) @(negedge clk);
    // R1: state while reset is held
    check("R1 flags in reset", {12'h0, flags_o}, 16'h0);
    check("R1 irq in reset", {15'h0, irq_o}, 16'h0);
    rst = 1'b0;
    for (int r = 0; r < 4; r++) begin
      read_reg(r[1:0], v);
      check($sformatf("R1 R9 reg %0d after reset", r), v, 16'h0000);
    end

    // vector walk: R3 R6 R7 R8 R9 R10
    for (int n = 0; n < NV; n++) begin
      int ch;
      logic [1:0] bf;
      logic [CW-1:0] cnt;
      bf = VEC[n][19:18]; ch = int'(VEC[n][17:16]); cnt = VEC[n][15:0];
      @(negedge clk); buf_en_i = bf;
      pulse(ch, cnt);
      expf = 4'b0000;
      if (ch < 2) begin
        if (bf[ch]) model[ch+2] = model[ch];
        model[ch] = cnt;
        expf[ch] = 1'b1;
      end else if (!bf[ch-2]) begin
        model[ch] = cnt;
        expf[ch] = 1'b1;
      end
      check($sformatf("R6 R7 R8 flags vec %0d", n), {12'h0, flags_o}, {12'h0, expf});
      for (int r = 0; r < 4; r++) begin
        read_reg(r[1:0], v);
        check($sformatf("R3 R6 R7 R8 R10 vec %0d reg %0d", n, r), v, model[r]);
      end
      clear_all();
    end

    // R2 / R5: exact latency and captured count
    @(negedge clk); buf_en_i = 2'b00; irq_en_i = 4'b0001;
    @(negedge clk); cap_pin_i[0] = 1'b1; count_i = 16'h0100; // before edge k
    @(negedge clk); count_i = 16'h0101;                       // after k
    @(negedge clk);                                           // after k+1
    check("R2 flag not yet set", {15'h0, flags_o[0]}, 16'h0);
    count_i = 16'h0102;
    @(negedge clk);                                           // after k+2
    check("R2 flag set at k+2", {15'h0, flags_o[0]}, 16'h1);
    check("R5 irq not yet", {15'h0, irq_o}, 16'h0);
    count_i = 16'h0103;
    @(negedge clk);                                           // after k+3
    check("R5 irq raised", {15'h0, irq_o}, 16'h1);
    model[0] = 16'h0102;
    cap_pin_i[0] = 1'b0;
    repeat (5) @(negedge clk);
    read_reg(2'd0, v);
    check("R2 captured count", v, 16'h0102);
    clear_all();
    @(negedge clk);
    check("R5 irq drops after clear", {15'h0, irq_o}, 16'h0);

    // R5: disabled channel does not request
    irq_en_i = 4'b0001;
    pulse(1, 16'h2468);
    check("R5 disabled flag gives no irq", {15'h0, irq_o}, 16'h0);
    check("R5 flag B still set", {15'h0, flags_o[1]}, 16'h1);
    clear_all();

    // R4: capture wins over a clear in the same cycle
    pulse(0, 16'h3000);
    @(negedge clk); cap_pin_i[0] = 1'b1; count_i = 16'h3001; // before k
    @(negedge clk);                                           // after k
    @(negedge clk); clr_we_i = 1'b1; clr_mask_i = 4'b0001;   // sampled at k+2
    @(negedge clk); clr_we_i = 1'b0; clr_mask_i = 4'b0000;
    check("R4 capture beats clear", {15'h0, flags_o[0]}, 16'h1);
    @(negedge clk); clr_we_i = 1'b1; clr_mask_i = 4'b0001;
    @(negedge clk); clr_we_i = 1'b0; clr_mask_i = 4'b0000;
    check("R4 clear alone", {15'h0, flags_o[0]}, 16'h0);
    cap_pin_i[0] = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 return edge ignored", {12'h0, flags_o}, 16'h0);
    read_reg(2'd0, v);
    check("R4 value of won capture", v, 16'h3001);

    summary();
  end
endmodule